// File: doc/BRIEF.md
# Peripheral Register Access Bridge

This bridge connects a processor or DMA data port, addressed in a 28-bit space, to a 16-bit bus of on-chip peripheral registers that occupy one 4 KB window. It decides whether each request lands in the window, in a forbidden mirror of it, in external memory, or nowhere it serves. It then shapes the request to fit the register it targets.

Word requests are split into two halfword bus cycles, lower address first. Byte-wide registers are written and read on the low lane only. Offsets that hold no register, instruction fetches into the window, and any touch of the mirror never reach the register bus. Instead each such request raises a one-cycle flag alongside its response.

The requester holds its request steady with `reqValid` high until `reqReady` pulses. Read data and all flags are valid only in that cycle. The register side is a single-cycle bus: read data must be valid in the same cycle as `pSel`.

Top module: `periph_bridge`

## Requirements
- R1: Addresses 0xFFFF000 to 0xFFFFFFF (bits 27:12 all equal to 0xFFFF) are the window. A legal window access drives bits 11:0 of the address onto `pAddr` with `pAddr[0]` forced to 0, and a halfword read returns the register value in `rspRdata[15:0]` with zeros above.
- R2: Address bit 0 is never decoded. A byte or halfword request to odd address 2n+1 reaches the register at 2n.
- R3: Addresses with bits 27:12 equal to 0x3FFF (the mirror) never assert `pSel`, raise `errMirror`, and read as zero. This holds for data, DMA and fetch requests alike, and a mirror request raises no other flag.
- R4: `reqSize` 2 (word) ignores address bits 1:0 and performs two bus cycles, at offset 0 then offset 2 of the aligned word. `rspRdata[15:0]` holds the lower halfword and `rspRdata[31:16]` the upper one. `reqReady` comes two clock edges after the request is taken, versus one edge for byte and halfword requests.
- R5: With default parameters, offsets 0x000 to 0x0FF are halfword registers and 0x100 to 0x1FF are byte registers. Any read of a byte register returns zero in bits 15:8 of each halfword.
- R6: A write to a byte register drives `pWdata[15:8]` as zero, so only the low 8 bits of the write data are stored. A byte request (`reqSize` 0) takes its data from `reqWdata[7:0]`.
- R7: An instruction fetch (`reqFetch` high) into the window never asserts `pSel`, reads as zero and raises `errFetch`.
- R8: A request outside both the window and the mirror raises `extMem` when address bits 21:0 are at least 0x100000 and `romless` is 0. When `romless` is 1, it raises `extMem` for all of 0x000000 to 0x3FFFFF. Bits 27:22 do not take part, and window addresses never raise `extMem`.
- R9: A window request to an offset at 0x200 or above, or a byte request to a halfword register, raises `errReserved`. Such a request reads as zero and performs no register write.
- R10: `reqReady` is a single-cycle pulse, and `errMirror`, `errFetch`, `errReserved` and `extMem` are high only in the `reqReady` cycle. All are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present; held until reqReady |
| reqAddr | input | 28 | Request byte address |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word |
| reqWrite | input | 1 | 1 write, 0 read |
| reqFetch | input | 1 | Request is an instruction fetch |
| reqWdata | input | 32 | Write data, lower halfword in 15:0 |
| romless | input | 1 | External range mode select |
| reqReady | output | 1 | Completion pulse; response valid |
| rspRdata | output | 32 | Read data |
| errMirror | output | 1 | Mirror access refused |
| errFetch | output | 1 | Fetch into the window refused |
| errReserved | output | 1 | No register at the offset |
| extMem | output | 1 | Address lies in external memory |
| pSel | output | 1 | Register bus cycle strobe |
| pWrite | output | 1 | Register bus write |
| pAddr | output | 12 | Register offset, bit 0 zero |
| pWdata | output | 16 | Register write data |
| pRdata | input | 16 | Register read data, same cycle |

## Verification
The hardest situation to reach is the second half of a split word. Its bus address, write lane and data capture are never visible as a standalone request. The bench issues word writes and then word reads of the same location, and compares the composed 32-bit result. It also logs every register-bus address in order, to show the low-then-high sequence. Byte-lane masking on writes is confirmed by inspecting the bench's own register model, because reads of byte registers already mask the upper lane.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int ADDR_W = 28;
  localparam int OFF_W = 12;
  localparam int TAG_W = ADDR_W - OFF_W;
  localparam logic [TAG_W-1:0] WIN_TAG = 16'hFFFF;
  localparam logic [TAG_W-1:0] MIR_TAG = 16'h3FFF;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {W_NONE, W_BYTE, W_HALF} regWidth_e;

  typedef struct packed {
    logic go;     // perform one bus slot this cycle
    logic upper;  // slot is the upper half of a split word
  } strobe_t;
endpackage

// File: rtl/pbr_ctrl.sv
module pbr_ctrl
  import pbr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    needSplit,
  output strobe_t stb,
  output logic    reqReady
);
  typedef enum logic [1:0] {S_IDLE, S_HIGH, S_DONE} state_e;
  state_e state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    stb = '0;
    reqReady = 1'b0;
    nxt = state;
    case (state)
      S_IDLE: if (reqValid) begin
        stb.go = 1'b1;
        nxt = needSplit ? S_HIGH : S_DONE;
      end
      S_HIGH: begin
        stb.go = 1'b1;
        stb.upper = 1'b1;
        nxt = S_DONE;
      end
      S_DONE: begin
        reqReady = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/pbr_datapath.sv
module pbr_datapath
  import pbr_pkg::*;
#(
  parameter logic [OFF_W-1:0] HALF_END = 12'h100,
  parameter logic [OFF_W-1:0] BYTE_END = 12'h200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              reqWrite,
  input  logic              reqFetch,
  input  logic [31:0]       reqWdata,
  input  logic              romless,
  input  logic [15:0]       pRdata,
  output logic              pSel,
  output logic              pWrite,
  output logic [OFF_W-1:0]  pAddr,
  output logic [15:0]       pWdata,
  output logic              needSplit,
  output logic [31:0]       rdataQ,
  output logic [3:0]        flagQ   // {mirror, fetch, reserved, external}
);
  logic inWin, inMir, isWord, isByte, legal, extHit;
  logic [OFF_W-1:0] curOff;
  regWidth_e curW;
  logic [15:0] laneW, rdHalf;

  assign inWin  = reqAddr[ADDR_W-1:OFF_W] == WIN_TAG;
  assign inMir  = reqAddr[ADDR_W-1:OFF_W] == MIR_TAG;
  assign isWord = reqSize == SZ_WORD;
  assign isByte = reqSize == SZ_BYTE;
  assign extHit = !inWin && !inMir && (romless || (reqAddr[21:20] != 2'b00));

  always_comb begin
    curOff = {reqAddr[OFF_W-1:2], (isWord ? stb.upper : reqAddr[1]), 1'b0};
    if (curOff < HALF_END)      curW = W_HALF;
    else if (curOff < BYTE_END) curW = W_BYTE;
    else                        curW = W_NONE;
    legal = inWin && !reqFetch && (curW != W_NONE) && !(isByte && curW == W_HALF);
    laneW = (isWord && stb.upper) ? reqWdata[31:16] : reqWdata[15:0];
    if (curW == W_BYTE) laneW[15:8] = 8'h00;
    rdHalf = (legal && !reqWrite) ? pRdata : 16'h0000;
    if (curW == W_BYTE) rdHalf[15:8] = 8'h00;
  end

  assign pAddr     = curOff;
  assign pSel      = stb.go && legal;
  assign pWrite    = reqWrite;
  assign pWdata    = laneW;
  assign needSplit = isWord && inWin && !reqFetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdataQ <= '0;
      flagQ  <= '0;
    end else if (stb.go && !stb.upper) begin
      rdataQ <= {16'h0000, rdHalf};
      flagQ  <= {inMir, inWin && reqFetch, inWin && !reqFetch && !legal, extHit};
    end else if (stb.go && stb.upper) begin
      rdataQ[31:16] <= rdHalf;
      flagQ[1]      <= flagQ[1] | !legal;
    end
  end
endmodule

// File: rtl/periph_bridge.sv
module periph_bridge
  import pbr_pkg::*;
#(
  parameter logic [11:0] HALF_END = 12'h100,
  parameter logic [11:0] BYTE_END = 12'h200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic [27:0] reqAddr,
  input  logic [1:0]  reqSize,
  input  logic        reqWrite,
  input  logic        reqFetch,
  input  logic [31:0] reqWdata,
  input  logic        romless,
  output logic        reqReady,
  output logic [31:0] rspRdata,
  output logic        errMirror,
  output logic        errFetch,
  output logic        errReserved,
  output logic        extMem,
  output logic        pSel,
  output logic        pWrite,
  output logic [11:0] pAddr,
  output logic [15:0] pWdata,
  input  logic [15:0] pRdata
);
  strobe_t stb;
  logic needSplit;
  logic [3:0] flagQ;

  pbr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid),
    .needSplit(needSplit), .stb(stb), .reqReady(reqReady)
  );

  pbr_datapath #(.HALF_END(HALF_END), .BYTE_END(BYTE_END)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWrite(reqWrite), .reqFetch(reqFetch), .reqWdata(reqWdata),
    .romless(romless), .pRdata(pRdata), .pSel(pSel), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .needSplit(needSplit),
    .rdataQ(rspRdata), .flagQ(flagQ)
  );

  assign errMirror   = reqReady && flagQ[3];
  assign errFetch    = reqReady && flagQ[2];
  assign errReserved = reqReady && flagQ[1];
  assign extMem      = reqReady && flagQ[0];
endmodule

// File: rtl/periph_bridge_chk.sv
module periph_bridge_chk #(
  parameter logic [11:0] HALF_END = 12'h100,
  parameter logic [11:0] BYTE_END = 12'h200
) (
  input logic        clk,
  input logic        rst_n,
  input logic        reqValid,
  input logic [27:0] reqAddr,
  input logic [1:0]  reqSize,
  input logic        reqFetch,
  input logic        reqReady,
  input logic        errMirror,
  input logic        errFetch,
  input logic        errReserved,
  input logic        extMem,
  input logic        pSel,
  input logic        pWrite,
  input logic [11:0] pAddr,
  input logic [15:0] pWdata
);
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pSel |-> !pAddr[0]);

  p_mirror_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqAddr[27:12] == 16'h3FFF) |-> !pSel);

  p_word_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqSize == 2'd2 && pSel && !pAddr[1]) |=>
      (pSel && pAddr == ($past(pAddr) | 12'h002) && !reqReady));

  p_byte_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pSel && pWrite && pAddr >= HALF_END && pAddr < BYTE_END) |-> pWdata[15:8] == 8'h00);

  p_fetch_no_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqFetch && reqAddr[27:12] == 16'hFFFF) |-> !pSel);

  p_flag_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (errMirror || errFetch || errReserved || extMem) |-> reqReady);

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |=> !reqReady);
endmodule

bind periph_bridge periph_bridge_chk #(.HALF_END(HALF_END), .BYTE_END(BYTE_END)) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqSize(reqSize), .reqFetch(reqFetch), .reqReady(reqReady),
  .errMirror(errMirror), .errFetch(errFetch), .errReserved(errReserved),
  .extMem(extMem), .pSel(pSel), .pWrite(pWrite), .pAddr(pAddr), .pWdata(pWdata)
);

// File: tb/periph_bridge_bench.sv
module periph_bridge_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0;
  logic [27:0] reqAddr = '0;
  logic [1:0] reqSize = '0;
  logic reqWrite = 1'b0, reqFetch = 1'b0, romless = 1'b0;
  logic [31:0] reqWdata = '0;
  logic reqReady, errMirror, errFetch, errReserved, extMem, pSel, pWrite;
  logic [31:0] rspRdata;
  logic [11:0] pAddr;
  logic [15:0] pWdata, pRdata;

  logic [15:0] regs [0:2047];
  logic [11:0] busLog [0:7];
  int busN;
  logic logClr = 1'b0;
  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  periph_bridge u_periph_bridge (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqWrite(reqWrite), .reqFetch(reqFetch),
    .reqWdata(reqWdata), .romless(romless), .reqReady(reqReady),
    .rspRdata(rspRdata), .errMirror(errMirror), .errFetch(errFetch),
    .errReserved(errReserved), .extMem(extMem), .pSel(pSel), .pWrite(pWrite),
    .pAddr(pAddr), .pWdata(pWdata), .pRdata(pRdata)
  );

  // register model: value 0x1000 + slot index after reset
  assign pRdata = regs[pAddr[11:1]];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2048; i++) regs[i] <= 16'h1000 + 16'(i);
    end else if (pSel && pWrite) begin
      regs[pAddr[11:1]] <= pWdata;
    end
    if (logClr) busN <= 0;
    else if (pSel && busN < 8) begin
      busLog[busN] <= pAddr;
      busN <= busN + 1;
    end
  end

  typedef struct packed {
    logic [27:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic        fetch;
    logic        rl;
    logic [31:0] wdata;
    logic [31:0] expRd;
    logic [3:0]  expFlags; // {mirror, fetch, reserved, external}
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{28'hFFFF010, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00001008, 4'b0000, 4'd1},  // R1
    '{28'hFFFF011, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00001008, 4'b0000, 4'd2},  // R2
    '{28'hFFFF022, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 32'h10111010, 4'b0000, 4'd4},  // R4
    '{28'hFFFF104, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000082, 4'b0000, 4'd5},  // R5
    '{28'hFFFF105, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000082, 4'b0000, 4'd2},  // R2
    '{28'hFFFF010, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000000, 4'b0010, 4'd9},  // R9
    '{28'hFFFF300, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000000, 4'b0010, 4'd9},  // R9
    '{28'hFFFF1FF, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00FF00FE, 4'b0000, 4'd5},  // R5
    '{28'h3FFF010, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000000, 4'b1000, 4'd3},  // R3
    '{28'hFFFF010, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h00000000, 4'b0100, 4'd7},  // R7
    '{28'h3FFF010, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0, 32'h00000000, 4'b1000, 4'd3},  // R3
    '{28'h0100000, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000000, 4'b0001, 4'd8},  // R8
    '{28'h00FFFFF, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000000, 4'b0000, 4'd8},  // R8
    '{28'h0000000, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0, 32'h00000000, 4'b0001, 4'd8},  // R8
    '{28'hC3FFFFF, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h00000000, 4'b0001, 4'd8},  // R8
    '{28'hFFFF040, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000BEEF, 32'h0, 4'b0000, 4'd1},  // R1
    '{28'h3FFF040, 2'd1, 1'b1, 1'b0, 1'b0, 32'h00001111, 32'h0, 4'b1000, 4'd3},  // R3
    '{28'hFFFF040, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000BEEF, 4'b0000, 4'd3},  // R3
    '{28'hFFFF050, 2'd2, 1'b1, 1'b0, 1'b0, 32'h12345678, 32'h0, 4'b0000, 4'd4},  // R4
    '{28'hFFFF051, 2'd2, 1'b0, 1'b0, 1'b0, 32'h0, 32'h12345678, 4'b0000, 4'd4},  // R4
    '{28'hFFFF300, 2'd1, 1'b1, 1'b0, 1'b0, 32'h0000AAAA, 32'h0, 4'b0010, 4'd9},  // R9
    '{28'hFFFF000, 2'd1, 1'b0, 1'b0, 1'b1, 32'h0, 32'h00001000, 4'b0000, 4'd8}   // R8
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] gotRd;
  logic [3:0]  gotFlags;
  int          gotCycles;

  task automatic doReq(input logic [27:0] a, input logic [1:0] sz, input logic wr,
                       input logic fe, input logic rl, input logic [31:0] wd);
    reqAddr = a; reqSize = sz; reqWrite = wr; reqFetch = fe; romless = rl;
    reqWdata = wd; reqValid = 1'b1;
    gotCycles = 0;
    gotRd = 'x; gotFlags = 'x;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #2;
      gotCycles++;
      if (reqReady) begin
        gotRd = rspRdata;
        gotFlags = {errMirror, errFetch, errReserved, extMem};
        break;
      end
    end
    if (gotCycles >= 10) chk("handshake timeout", 32'(gotCycles), 32'd2);
    @(posedge clk); #1;
    reqValid = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10 reset ready", {31'b0, reqReady}, 32'h0);
    chk("R10 reset flags", {28'b0, errMirror, errFetch, errReserved, extMem}, 32'h0);
    chk("R10 reset rdata", rspRdata, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      doReq(VECS[v].addr, VECS[v].size, VECS[v].wr, VECS[v].fetch, VECS[v].rl, VECS[v].wdata);
      if (!VECS[v].wr) chk($sformatf("R%0d vec %0d rdata", VECS[v].req, v), gotRd, VECS[v].expRd);
      chk($sformatf("R%0d vec %0d flags", VECS[v].req, v), {28'b0, gotFlags}, {28'b0, VECS[v].expFlags});
    end

    // R6: halfword write to byte register keeps only the low 8 bits
    doReq(28'hFFFF110, 2'd1, 1'b1, 1'b0, 1'b0, 32'h00005A7C);
    chk("R6 half write to byte reg", {16'h0, regs[12'h088]}, 32'h0000007C);
    // R6 / R2: byte write at odd address lands on the even register, low lane
    doReq(28'hFFFF113, 2'd0, 1'b1, 1'b0, 1'b0, 32'hFFFF77C3);
    chk("R6 byte write odd addr", {16'h0, regs[12'h089]}, 32'h000000C3);
    // R9: reserved write (vector 20) left the model untouched
    chk("R9 reserved write ignored", {16'h0, regs[12'h180]}, 32'h00001180);

    // R4: latency and ordering of the split word
    logClr = 1'b1; @(posedge clk); #1; logClr = 1'b0;
    doReq(28'hFFFF060, 2'd2, 1'b1, 1'b0, 1'b0, 32'hCAFE0123);
    chk("R4 word latency", 32'(gotCycles), 32'd2);
    chk("R4 bus count", 32'(busN), 32'd2);
    chk("R4 first slot", {20'h0, busLog[0]}, 32'h060);
    chk("R4 second slot", {20'h0, busLog[1]}, 32'h062);
    chk("R4 upper stored", {16'h0, regs[12'h031]}, 32'h0000CAFE);
    doReq(28'hFFFF060, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R4 half latency", 32'(gotCycles), 32'd1);

    // R3 / R7: refused requests never touch the bus
    logClr = 1'b1; @(posedge clk); #1; logClr = 1'b0;
    doReq(28'h3FFF060, 2'd2, 1'b1, 1'b0, 1'b0, 32'h55555555);
    doReq(28'hFFFF060, 2'd1, 1'b0, 1'b1, 1'b0, 32'h0);
    chk("R3 R7 no bus cycles", 32'(busN), 32'd0);

    // R10: flag gone in the cycle after the response
    doReq(28'h3FFF000, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0);
    chk("R10 mirror pulse seen", {31'b0, gotFlags[3]}, 32'h1);
    #1;
    chk("R10 mirror flag cleared", {31'b0, errMirror}, 32'h0);
    chk("R10 ready cleared", {31'b0, reqReady}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule